// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the transmit and receive error counts of a CAN node and works out from them whether the node may take full part on the bus (error active), must signal errors only passively (error passive), or has to stay off the bus (bus off). The protocol engine feeds it single-cycle event pulses: transmit error, acknowledge error, receive error, good transmission and good reception. It also feeds the sampled bus level with a strobe once per bit time. The block answers with both 8-bit counters, a 2-bit state code, two warning flags and a bus-off flag. All of these outputs are registered or decoded from registers, so they update on the clock edge after an event.

Bus-off recovery is handled inside the block. While off the bus, the transmit counter is reused as a count of completed runs of 11 recessive bits. A small run counter tracks the recessive bits of the current run. After the 128th complete run the node rejoins as error active with both counters cleared.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. Each input pulse is consumed in the cycle where it is high.

Top module: `can_fault_guard`

## Requirements
- R1: After reset the state code is 00, both counters read 0, and `tx_warn`, `rx_warn` and `bus_off` are low.
- R2: Outside bus off, a `tx_err_pls` adds 8 to `tec`. A `tx_ok_pls` subtracts 1 from `tec`, and `tec` never goes below 0.
- R3: Outside bus off, an `rx_err_pls` adds 1 to `rec` only while `rec` is 127 or less, so `rec` never exceeds 128. An `rx_ok_pls` subtracts 1 from `rec` when `rec` is between 1 and 127.
- R4: An `rx_ok_pls` while `rec` is 128 loads `rec` with 119.
- R5: The state code `node_state` takes one of three values. It is 10 in bus off, and `bus_off` is high exactly then. Otherwise it is 01 when `tec` or `rec` is 128 or more, and 00 when both are below 128.
- R6: `tx_warn` is high when `tec` is 96 or more, and also throughout bus off. `rx_warn` is high when `rec` is 96 or more.
- R7: An `ack_err_pls` adds 8 to `tec` only in state 00. In state 01 it leaves `tec` unchanged.
- R8: A transmit error (a `tx_err_pls`, or an `ack_err_pls` in state 00) that would take `tec` to 256 or more enters bus off. `tec` is then set to 0 and becomes the recovery run count.
- R9: In bus off, the transmit, acknowledge and receive event pulses have no effect, and `rec` holds its value.
- R10: In bus off, each `bit_stb` with `bus_bit` high (recessive) extends the current run. The 11th consecutive recessive bit adds 1 to `tec` and starts a new run from zero.
- R11: In bus off, a `bit_stb` with `bus_bit` low (dominant) before a run completes discards the run and leaves `tec` unchanged.
- R12: Completing the 128th run returns the node to state 00 with `tec` and `rec` both 0.
- R13: When an error pulse and a success pulse for the same counter arrive in the same cycle, only the error is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_pls | input | 1 | Transmit error detected |
| ack_err_pls | input | 1 | Acknowledge missing on own frame |
| rx_err_pls | input | 1 | Receive error detected |
| tx_ok_pls | input | 1 | Frame transmitted successfully |
| rx_ok_pls | input | 1 | Frame received successfully |
| bit_stb | input | 1 | One pulse per bit time, qualifies `bus_bit` |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| tec | output | 8 | Transmit error count; recovery run count in bus off |
| rec | output | 8 | Receive error count |
| node_state | output | 2 | 00 active, 01 passive, 10 bus off |
| tx_warn | output | 1 | Transmit count at warning level or bus off |
| rx_warn | output | 1 | Receive count at warning level |
| bus_off | output | 1 | Node is off the bus |

## Verification
Almost all internal state in this block is visible at the ports. A wrong count shows up on `tec` or `rec` at the sample after the event pulse, and a wrong state code follows in the same cycle because it is decoded from the counters. The one hidden register is the recessive-run counter. An error in it first shows one bit time after the 11th recessive bit, as an early, late or missing step of `tec`. The dominant-bit test therefore stops one bit short of a complete run and checks that `tec` has not moved.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/fc_run_counter.sv
// Counts consecutive recessive bits while the node is off the bus.
module fc_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_stb,
  input  logic bus_bit,
  output logic run_done
);
  localparam int RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;

  assign run_done = enable & bit_stb & bus_bit & (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!enable) begin
      run_q <= '0;
    end else if (bit_stb) begin
      if (!bus_bit || run_done) run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/fc_tx_counter.sv
// Transmit error counter; doubles as recovery run count in bus off.
module fc_tx_counter #(
  parameter int CNT_W   = 8,
  parameter int STEP    = 8,
  parameter int RECOV_N = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             ack_err,
  input  logic             tx_ok,
  input  logic             passive,
  input  logic             in_boff,
  input  logic             run_done,
  output logic [CNT_W-1:0] tec,
  output logic             enter_boff,
  output logic             recov_done
);
  localparam logic [CNT_W:0]   STEP_X  = (CNT_W + 1)'(STEP);
  localparam logic [CNT_W-1:0] LAST_RN = CNT_W'(RECOV_N - 1);

  logic [CNT_W-1:0] tec_q;
  logic [CNT_W:0]   sum;
  logic             err_hit;

  assign sum        = {1'b0, tec_q} + STEP_X;
  assign err_hit    = ~in_boff & (tx_err | (ack_err & ~passive));
  assign enter_boff = err_hit & sum[CNT_W];
  assign recov_done = in_boff & run_done & (tec_q == LAST_RN);
  assign tec        = tec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
    end else if (in_boff) begin
      if (recov_done)    tec_q <= '0;
      else if (run_done) tec_q <= tec_q + 1'b1;
    end else if (err_hit) begin
      tec_q <= enter_boff ? '0 : sum[CNT_W-1:0];
    end else if (tx_ok && tec_q != '0) begin
      tec_q <= tec_q - 1'b1;
    end
  end
endmodule

// File: rtl/fc_rx_counter.sv
// Receive error counter with saturation and reload window.
module fc_rx_counter #(
  parameter int CNT_W     = 8,
  parameter int PASS_LVL  = 128,
  parameter int RELOAD_TO = 119
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             in_boff,
  input  logic             clear,
  output logic [CNT_W-1:0] rec
);
  localparam logic [CNT_W-1:0] PASS_V   = CNT_W'(PASS_LVL);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD_TO);

  logic [CNT_W-1:0] rec_q;
  logic             high;

  assign high = (rec_q >= PASS_V);
  assign rec  = rec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (clear) begin
      rec_q <= '0;
    end else if (!in_boff) begin
      if (rx_err) begin
        if (!high) rec_q <= rec_q + 1'b1;
      end else if (rx_ok) begin
        if (high)               rec_q <= RELOAD_V;
        else if (rec_q != '0)   rec_q <= rec_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard #(
  parameter int CNT_W     = 8,
  parameter int TX_STEP   = 8,
  parameter int PASS_LVL  = 128,
  parameter int WARN_LVL  = 96,
  parameter int RELOAD_TO = 119,
  parameter int RUN_LEN   = 11,
  parameter int RECOV_N   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_pls,
  input  logic             ack_err_pls,
  input  logic             rx_err_pls,
  input  logic             tx_ok_pls,
  input  logic             rx_ok_pls,
  input  logic             bit_stb,
  input  logic             bus_bit,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       node_state,
  output logic             tx_warn,
  output logic             rx_warn,
  output logic             bus_off
);
  import fc_pkg::*;

  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LVL);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LVL);

  logic      boff_q;
  logic      passive;
  logic      run_done;
  logic      enter_boff;
  logic      recov_done;
  fc_state_e st;

  assign passive = ~boff_q & ((tec >= PASS_V) | (rec >= PASS_V));

  fc_run_counter #(.RUN_LEN(RUN_LEN)) run_i (
    .clk(clk), .rst_n(rst_n), .enable(boff_q),
    .bit_stb(bit_stb), .bus_bit(bus_bit), .run_done(run_done)
  );

  fc_tx_counter #(.CNT_W(CNT_W), .STEP(TX_STEP), .RECOV_N(RECOV_N)) txc_i (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err_pls), .ack_err(ack_err_pls),
    .tx_ok(tx_ok_pls), .passive(passive), .in_boff(boff_q),
    .run_done(run_done), .tec(tec), .enter_boff(enter_boff),
    .recov_done(recov_done)
  );

  fc_rx_counter #(.CNT_W(CNT_W), .PASS_LVL(PASS_LVL), .RELOAD_TO(RELOAD_TO)) rxc_i (
    .clk(clk), .rst_n(rst_n), .rx_err(rx_err_pls), .rx_ok(rx_ok_pls),
    .in_boff(boff_q), .clear(recov_done), .rec(rec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          boff_q <= 1'b0;
    else if (enter_boff) boff_q <= 1'b1;
    else if (recov_done) boff_q <= 1'b0;
  end

  always_comb begin
    if (boff_q)       st = FC_BUSOFF;
    else if (passive) st = FC_PASSIVE;
    else              st = FC_ACTIVE;
  end

  assign node_state = st;
  assign bus_off    = boff_q;
  assign tx_warn    = boff_q | (tec >= WARN_V);
  assign rx_warn    = rec >= WARN_V;
endmodule

// File: rtl/can_fault_guard_chk.sv
module can_fault_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err_pls,
  input logic             ack_err_pls,
  input logic             rx_err_pls,
  input logic             tx_ok_pls,
  input logic             bit_stb,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic [1:0]       node_state,
  input logic             bus_off
);
  // R3
  rec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec <= CNT_W'(128));

  // R5
  state_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'b10) == bus_off);

  // R7
  ack_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'b01 && ack_err_pls && !tx_err_pls && !tx_ok_pls) |=> $stable(tec));

  // R8
  boff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && tx_err_pls && tec >= CNT_W'(248)) |=> (bus_off && tec == '0));

  // R9
  boff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !bit_stb) |=> ($stable(tec) && $stable(rec)));

  // R12
  recov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> (tec == '0 && rec == '0 && node_state == 2'b00));

  // R9
  boff_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && rx_err_pls) |=> (rec <= $past(rec)));
endmodule

bind can_fault_guard can_fault_guard_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_err_pls(tx_err_pls), .ack_err_pls(ack_err_pls),
  .rx_err_pls(rx_err_pls), .tx_ok_pls(tx_ok_pls), .bit_stb(bit_stb),
  .tec(tec), .rec(rec), .node_state(node_state), .bus_off(bus_off)
);

// File: tb/can_fault_guard_tb_top.sv
module can_fault_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err_pls = 0, ack_err_pls = 0, rx_err_pls = 0, tx_ok_pls = 0, rx_ok_pls = 0;
  logic bit_stb = 0, bus_bit = 1;
  logic [7:0] tec, rec;
  logic [1:0] node_state;
  logic tx_warn, rx_warn, bus_off;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_fault_guard dut_i (
    .clk(clk), .rst_n(rst_n), .tx_err_pls(tx_err_pls), .ack_err_pls(ack_err_pls),
    .rx_err_pls(rx_err_pls), .tx_ok_pls(tx_ok_pls), .rx_ok_pls(rx_ok_pls),
    .bit_stb(bit_stb), .bus_bit(bus_bit), .tec(tec), .rec(rec),
    .node_state(node_state), .tx_warn(tx_warn), .rx_warn(rx_warn), .bus_off(bus_off)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // mask bits: 4 tx_err, 3 ack_err, 2 rx_err, 1 tx_ok, 0 rx_ok
  task automatic pulse(logic [4:0] m, int n);
    for (int i = 0; i < n; i++) begin
      {tx_err_pls, ack_err_pls, rx_err_pls, tx_ok_pls, rx_ok_pls} = m;
      @(negedge clk);
      {tx_err_pls, ack_err_pls, rx_err_pls, tx_ok_pls, rx_ok_pls} = '0;
      @(negedge clk);
    end
  endtask

  task automatic send_bits(logic v, int n);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1'b1;
      bus_bit = v;
      @(negedge clk);
      bit_stb = 1'b0;
      bus_bit = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", node_state, 0);
    check("R1 tec", tec, 0);
    check("R1 rec", rec, 0);
    check("R1 flags", {tx_warn, rx_warn, bus_off}, 0);
  endtask

  task automatic t_tx_count();
    do_reset();
    pulse(5'b10000, 3);
    check("R2 tx err step", tec, 24);
    pulse(5'b00010, 1);
    check("R2 tx ok", tec, 23);
    pulse(5'b00010, 23);
    pulse(5'b00010, 1);
    check("R2 floor", tec, 0);
  endtask

  task automatic t_warn_passive();
    do_reset();
    pulse(5'b10000, 11);
    check("R6 below warn", tx_warn, 0);
    pulse(5'b10000, 1);
    check("R6 tx warn 96", tx_warn, 1);
    check("R5 still active", node_state, 0);
    pulse(5'b10000, 4);
    check("R5 passive tec128", node_state, 1);
  endtask

  task automatic t_ack();
    do_reset();
    pulse(5'b01000, 16);
    check("R7 ack active", tec, 128);
    pulse(5'b01000, 3);
    check("R7 ack passive", tec, 128);
    check("R7 state", node_state, 1);
  endtask

  task automatic t_rx();
    do_reset();
    pulse(5'b00100, 95);
    check("R6 rx warn low", rx_warn, 0);
    pulse(5'b00100, 1);
    check("R6 rx warn 96", rx_warn, 1);
    pulse(5'b00100, 32);
    check("R3 rec 128", rec, 128);
    check("R5 passive rec", node_state, 1);
    pulse(5'b00100, 2);
    check("R3 saturate", rec, 128);
    pulse(5'b00001, 1);
    check("R4 reload", rec, 119);
    check("R4 active again", node_state, 0);
    pulse(5'b00001, 1);
    check("R3 rx ok dec", rec, 118);
  endtask

  task automatic t_tie();
    do_reset();
    pulse(5'b10010, 1);
    check("R13 tx tie", tec, 8);
    pulse(5'b00101, 1);
    check("R13 rx tie", rec, 1);
  endtask

  task automatic t_busoff_recovery();
    do_reset();
    pulse(5'b00100, 5);
    pulse(5'b10000, 31);
    check("R8 pre", tec, 248);
    pulse(5'b10000, 1);
    check("R8 state", node_state, 2);
    check("R8 flag", bus_off, 1);
    check("R8 tec cleared", tec, 0);
    check("R6 warn in boff", tx_warn, 1);
    pulse(5'b11111, 2);
    check("R9 tec held", tec, 0);
    check("R9 rec held", rec, 5);
    send_bits(1'b1, 10);
    send_bits(1'b0, 1);
    send_bits(1'b1, 10);
    check("R11 dominant break", tec, 0);
    send_bits(1'b0, 1);
    send_bits(1'b1, 11);
    check("R10 one run", tec, 1);
    send_bits(1'b1, 11 * 126);
    check("R10 runs", tec, 127);
    check("R12 still off", bus_off, 1);
    send_bits(1'b1, 11);
    check("R12 state", node_state, 0);
    check("R12 tec", tec, 0);
    check("R12 rec", rec, 0);
  endtask

  initial begin
    t_reset();
    t_tx_count();
    t_warn_passive();
    t_ack();
    t_rx();
    t_tie();
    t_busoff_recovery();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule